// File: doc/BRIEF.md
# Signed-Count Logical Shift Unit

This block is the logical shift stage of a small CPU datapath. One two's-complement count sets both the direction and the distance of the shift. A positive count moves the operand toward the MSB and a negative count moves it toward the LSB. Vacated positions are always filled with zeros. The operand can be treated as a byte, a word or a long. In byte and word modes, the bits above the selected width pass through untouched.

The shifted result is purely combinational. Three condition flags (sign, zero, carry) are held in registers. They load on a clock edge only when the enable strobe is high and the count is legal and nonzero. The carry takes the last bit pushed off the edge of the operand. A separate input marks the count as coming from an immediate field, which narrows the legal range. An illegal count drops `cnt_ok_o`, passes the operand through and leaves the flags alone, so every input combination has a defined outcome.

Top module: `lsh_unit`

## Requirements
- R1: With a legal count n > 0, the low W bits of `res_o` equal the low W bits of the operand shifted toward the MSB by n, with zeros filled in. W is 8, 16 or 32 for `size_i` = 00, 01, 10.
- R2: With a legal count n < 0, the low W bits of `res_o` equal the low W bits of the operand shifted toward the LSB by |n|, with zeros filled in.
- R3: On an updating shift in byte or word mode, the carry flag takes the last bit shifted out. For a left shift by n this is operand bit W-n. For a right shift by |n| it is operand bit |n|-1.
- R4: On an updating shift, the sign flag takes bit W-1 of the result.
- R5: On an updating shift in byte or word mode, the zero flag is set exactly when the low W bits of the result are all zero.
- R6: When `imm_i` is 0, a count is legal if its magnitude is at most 8 in byte mode, or at most 16 in word and long modes. `cnt_ok_o` is 1 exactly for legal counts. `cnt_i` is 6-bit two's complement.
- R7: When `imm_i` is 1, a count is legal only if its magnitude is 1 to 8, in any mode. A zero count is illegal in this form.
- R8: For an illegal count, or for `size_i` = 11, `cnt_ok_o` is 0, `res_o` equals `opnd_i` and no flag changes.
- R9: A legal zero count returns the operand unchanged in `res_o` and leaves all three flags unchanged.
- R10: In long mode an updating shift loads only the sign flag. The zero and carry flags keep their values.
- R11: In byte and word modes, `res_o` bits above the selected width equal the corresponding `opnd_i` bits.
- R12: The flags change only on a clock edge where `en_i` is 1 and the count is legal and nonzero. A synchronous `rst` clears all three flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Flag update strobe |
| size_i | input | 2 | Operand width: 00 byte, 01 word, 10 long |
| cnt_i | input | 6 | Signed shift count (two's complement) |
| imm_i | input | 1 | Count comes from an immediate field |
| opnd_i | input | 32 | Operand |
| res_o | output | 32 | Shifted result |
| sflag_o | output | 1 | Sign flag |
| zflag_o | output | 1 | Zero flag |
| cflag_o | output | 1 | Carry flag |
| cnt_ok_o | output | 1 | Count is legal for the current mode |

## Verification
The cycle-by-cycle properties cover the hold rules and the edge-bit rules. Flags stay put when the strobe is low, when the count is zero and when the count is illegal. Zero and carry stay put in long mode. The sign flag follows the result MSB after an update. An illegal count passes the operand through, and the bits above the width are preserved. The exact shifted values, the choice of the carry bit at each distance, and the boundary counts of each range (±8, ±9, ±16, ±17, immediate zero) are shown only by the bench's directed and pseudo-random scenarios, which compare against a bit-by-bit reference model.

// File: rtl/lsh_pkg.sv
package lsh_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef struct packed {
        logic s;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/lsh_range_chk.sv
// Decodes the signed count into direction and magnitude and judges legality.
module lsh_range_chk #(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 6,
    parameter int IMM_MAX = 8
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       size,
    input  logic             imm,
    output logic [CNT_W:0]   mag,
    output logic             left,
    output logic             ok
);
    import lsh_pkg::*;

    localparam int BYTE_W = DATA_W / 4;
    localparam int WORD_W = DATA_W / 2;
    localparam logic [CNT_W:0] LIM_B = (CNT_W+1)'(BYTE_W);
    localparam logic [CNT_W:0] LIM_W = (CNT_W+1)'(WORD_W);
    localparam logic [CNT_W:0] LIM_I = (CNT_W+1)'(IMM_MAX);

    logic [CNT_W:0] ext;
    logic [CNT_W:0] lim;

    always_comb begin
        ext  = {cnt[CNT_W-1], cnt};
        left = ~cnt[CNT_W-1];
        mag  = cnt[CNT_W-1] ? (~ext + 1'b1) : ext;
        case (size_e'(size))
            SZ_BYTE: lim = LIM_B;
            default: lim = LIM_W;
        endcase
        if (imm) begin
            lim = LIM_I;
        end
        ok = (size_e'(size) != SZ_RSVD) && (mag <= lim) && !(imm && mag == '0);
    end

endmodule

// File: rtl/lsh_lane.sv
// Zero-fill shifter of one fixed width, also yielding the last bit shifted out.
module lsh_lane #(
    parameter int W     = 8,
    parameter int AMT_W = 7
) (
    input  logic [W-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    input  logic             left,
    output logic [W-1:0]     dout,
    output logic             cout
);
    logic [W:0] l_ext;
    logic [W:0] r_ext;

    always_comb begin
        l_ext = {1'b0, din} << amt;
        r_ext = {din, 1'b0} >> amt;
        if (left) begin
            dout = l_ext[W-1:0];
            cout = l_ext[W];
        end else begin
            dout = r_ext[W:1];
            cout = r_ext[0];
        end
    end

endmodule

// File: rtl/lsh_unit.sv
module lsh_unit
    import lsh_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 6,
    parameter int IMM_MAX = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [1:0]        size_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              imm_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [DATA_W-1:0] res_o,
    output logic              sflag_o,
    output logic              zflag_o,
    output logic              cflag_o,
    output logic              cnt_ok_o
);

    localparam int N_LANE = 3;
    localparam int AMT_W  = CNT_W + 1;

    logic [AMT_W-1:0]  mag;
    logic              left;
    logic              ok;

    logic [DATA_W-1:0] lane_res  [4];
    logic              lane_msb  [4];
    logic              lane_zero [4];
    logic              lane_c    [4];

    flags_t            flg_d, flg_q;
    logic [DATA_W-1:0] res_d;
    logic [1:0]        sel;

    lsh_range_chk #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .IMM_MAX(IMM_MAX)
    ) u_range (
        .cnt (cnt_i),
        .size(size_i),
        .imm (imm_i),
        .mag (mag),
        .left(left),
        .ok  (ok)
    );

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        localparam int LW = (DATA_W / 4) << g;
        logic [LW-1:0] dq;
        logic          cq;

        lsh_lane #(
            .W    (LW),
            .AMT_W(AMT_W)
        ) u_lane (
            .din (opnd_i[LW-1:0]),
            .amt (mag),
            .left(left),
            .dout(dq),
            .cout(cq)
        );

        if (LW < DATA_W) begin : g_keep_hi
            assign lane_res[g] = {opnd_i[DATA_W-1:LW], dq};
        end else begin : g_full
            assign lane_res[g] = dq;
        end
        assign lane_msb[g]  = dq[LW-1];
        assign lane_zero[g] = ~|dq;
        assign lane_c[g]    = cq;
    end

    // Reserved size slot: never selected while the count is legal.
    assign lane_res[3]  = opnd_i;
    assign lane_msb[3]  = 1'b0;
    assign lane_zero[3] = 1'b0;
    assign lane_c[3]    = 1'b0;

    always_comb begin
        flg_d = flg_q;
        sel   = size_i;
        res_d = opnd_i;
        if (ok) begin
            res_d = lane_res[sel];
        end
        if (en_i && ok && mag != '0) begin
            flg_d.s = lane_msb[sel];
            if (size_e'(size_i) != SZ_LONG) begin
                flg_d.z = lane_zero[sel];
                flg_d.c = lane_c[sel];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign res_o    = res_d;
    assign cnt_ok_o = ok;
    assign sflag_o  = flg_q.s;
    assign zflag_o  = flg_q.z;
    assign cflag_o  = flg_q.c;

endmodule

// File: rtl/lsh_unit_chk.sv
module lsh_unit_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              en_i,
    input logic [1:0]        size_i,
    input logic [CNT_W-1:0]  cnt_i,
    input logic              imm_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic [DATA_W-1:0] res_o,
    input logic              sflag_o,
    input logic              zflag_o,
    input logic              cflag_o,
    input logic              cnt_ok_o
);
    logic msb_now;
    logic upd;

    always_comb begin
        case (size_i)
            2'b00:   msb_now = res_o[DATA_W/4-1];
            2'b01:   msb_now = res_o[DATA_W/2-1];
            default: msb_now = res_o[DATA_W-1];
        endcase
        upd = en_i && cnt_ok_o && (cnt_i != '0);
    end

    // R12: reset clears every flag
    a_r12_reset_clear: assert property (@(posedge clk)
        rst |=> (!sflag_o && !zflag_o && !cflag_o));

    // R12: no strobe, no flag change
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> ($stable(sflag_o) && $stable(zflag_o) && $stable(cflag_o)));

    // R9: zero count leaves flags alone
    a_r9_zero_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt_i == '0) |=> ($stable(sflag_o) && $stable(zflag_o) && $stable(cflag_o)));

    // R8: illegal count leaves flags alone
    a_r8_bad_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_ok_o |=> ($stable(sflag_o) && $stable(zflag_o) && $stable(cflag_o)));

    // R8: illegal count passes the operand through
    a_r8_bad_pass: assert property (@(posedge clk) disable iff (rst)
        !cnt_ok_o |-> (res_o == opnd_i));

    // R8: reserved size never legal
    a_r8_rsvd_size: assert property (@(posedge clk) disable iff (rst)
        (size_i == 2'b11) |-> !cnt_ok_o);

    // R10: long mode keeps zero and carry
    a_r10_long_zc: assert property (@(posedge clk) disable iff (rst)
        (size_i == 2'b10) |=> ($stable(zflag_o) && $stable(cflag_o)));

    // R4: sign flag follows the result MSB after an update
    a_r4_sign_msb: assert property (@(posedge clk) disable iff (rst)
        upd |=> (sflag_o == $past(msb_now)));

    // R11: bits above the byte width are preserved
    a_r11_byte_hi: assert property (@(posedge clk) disable iff (rst)
        (size_i == 2'b00) |-> (res_o[DATA_W-1:DATA_W/4] == opnd_i[DATA_W-1:DATA_W/4]));

    // R11: bits above the word width are preserved
    a_r11_word_hi: assert property (@(posedge clk) disable iff (rst)
        (size_i == 2'b01) |-> (res_o[DATA_W-1:DATA_W/2] == opnd_i[DATA_W-1:DATA_W/2]));

    // R7: immediate zero count is illegal
    a_r7_imm_zero: assert property (@(posedge clk) disable iff (rst)
        (imm_i && cnt_i == '0) |-> !cnt_ok_o);

endmodule

bind lsh_unit lsh_unit_chk #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_i),
    .size_i  (size_i),
    .cnt_i   (cnt_i),
    .imm_i   (imm_i),
    .opnd_i  (opnd_i),
    .res_o   (res_o),
    .sflag_o (sflag_o),
    .zflag_o (zflag_o),
    .cflag_o (cflag_o),
    .cnt_ok_o(cnt_ok_o)
);

// File: tb/lsh_unit_tb.sv
module lsh_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b0;
    logic [1:0]  size_i = 2'b00;
    logic [5:0]  cnt_i = '0;
    logic        imm_i = 1'b0;
    logic [31:0] opnd_i = '0;
    logic [31:0] res_o;
    logic        sflag_o, zflag_o, cflag_o, cnt_ok_o;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [31:0] res;
        logic        ok;
        logic        s, z, c;
        string       tag;
    } item_t;

    item_t q[$];
    logic  ms = 1'b0, mz = 1'b0, mc = 1'b0;

    always #4 clk = ~clk;

    lsh_unit u_dut (
        .clk(clk), .rst(rst), .en_i(en_i), .size_i(size_i), .cnt_i(cnt_i),
        .imm_i(imm_i), .opnd_i(opnd_i), .res_o(res_o), .sflag_o(sflag_o),
        .zflag_o(zflag_o), .cflag_o(cflag_o), .cnt_ok_o(cnt_ok_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Reference model and driver: push the expected result and the flags after the edge.
    task automatic drive(input logic [31:0] op, input logic [1:0] sz, input int cnt,
                         input logic imm, input logic en, input string tag);
        item_t it;
        int w, n, lim;
        logic ok, cy;
        logic [31:0] r;
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        n = (cnt < 0) ? -cnt : cnt;
        lim = imm ? 8 : (sz == 2'b00 ? 8 : 16);
        ok = (sz != 2'b11) && (n <= lim) && !(imm && n == 0);
        r = op;
        cy = 1'b0;
        if (ok && n != 0) begin
            for (int i = 0; i < w; i++) begin
                if (cnt > 0) r[i] = (i - n >= 0) ? op[i-n] : 1'b0;
                else         r[i] = (i + n < w) ? op[i+n] : 1'b0;
            end
            cy = (cnt > 0) ? op[w-n] : op[n-1];
            if (en) begin
                ms = r[w-1];
                if (w != 32) begin
                    mz = 1'b1;
                    for (int i = 0; i < w; i++) if (r[i]) mz = 1'b0;
                    mc = cy;
                end
            end
        end
        @(negedge clk);
        opnd_i = op; size_i = sz; cnt_i = 6'(cnt); imm_i = imm; en_i = en;
        it.res = r; it.ok = ok; it.s = ms; it.z = mz; it.c = mc; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: after each edge, compare the held result and the freshly loaded flags.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check({it.tag, " res"}, res_o, it.res);
            check({it.tag, " ok"}, {31'b0, cnt_ok_o}, {31'b0, it.ok});
            check({it.tag, " flags"}, {29'b0, sflag_o, zflag_o, cflag_o},
                  {29'b0, it.s, it.z, it.c});
        end
    end

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        check("R12 reset flags", {29'b0, sflag_o, zflag_o, cflag_o}, 32'h0);

        drive(32'hAAAA_55B5, 2'b00, 3, 1'b0, 1'b1, "R1 R3 R11 byte left 3");
        drive(32'h1234_56B5, 2'b00, -3, 1'b0, 1'b1, "R2 R3 byte right 3");
        drive(32'h0000_0080, 2'b00, -8, 1'b0, 1'b1, "R5 byte right 8 zero");
        drive(32'h0000_0081, 2'b00, 8, 1'b0, 1'b1, "R3 R6 byte left 8");
        drive(32'h0000_0081, 2'b00, 9, 1'b0, 1'b1, "R6 R8 byte 9 illegal");
        drive(32'hFFFF_0001, 2'b01, 16, 1'b0, 1'b1, "R3 R6 word left 16");
        drive(32'h5555_8000, 2'b01, -16, 1'b0, 1'b1, "R2 R3 word right 16");
        drive(32'h0000_4001, 2'b01, 1, 1'b0, 1'b1, "R1 R4 word left 1");
        drive(32'h0000_4001, 2'b01, -17, 1'b0, 1'b1, "R6 R8 word 17 illegal");
        drive(32'h0000_4001, 2'b01, 0, 1'b0, 1'b1, "R9 zero count");
        drive(32'h8000_0001, 2'b10, 1, 1'b0, 1'b1, "R10 long left 1");
        drive(32'h8000_0001, 2'b10, -16, 1'b0, 1'b1, "R2 R10 long right 16");
        drive(32'h0000_00F0, 2'b01, 9, 1'b1, 1'b1, "R7 imm 9 illegal");
        drive(32'h0000_00F0, 2'b01, 9, 1'b0, 1'b1, "R6 reg 9 legal");
        drive(32'h0000_00F0, 2'b00, 0, 1'b1, 1'b1, "R7 imm zero illegal");
        drive(32'h0000_00F0, 2'b00, -8, 1'b1, 1'b1, "R7 imm -8 legal");
        drive(32'hDEAD_BEEF, 2'b11, 2, 1'b0, 1'b1, "R8 reserved size");
        drive(32'h0000_00FF, 2'b00, 4, 1'b0, 1'b0, "R12 strobe low");
        lfsr = 32'h1ACE_B00C;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            drive(lfsr * 32'h9E37_79B9, lfsr[1:0], int'($signed(lfsr[13:8])),
                  lfsr[20] & lfsr[21], lfsr[25] | lfsr[26], "R1 R2 R3 R5 random");
        end
        @(negedge clk);
        en_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule